// File: doc/BRIEF.md
# Watermark-Driven DMA Request Pacer for a Serial Peripheral

This block sits between the two FIFOs of a serial peripheral and an external DMA engine. It keeps a small register set: one control word with separate transmit and receive DMA enable bits, an 8-bit watermark for each direction, and a global peripheral enable. It compares the fill count of each FIFO with that direction's watermark and raises burst requests toward the DMA engine. Each burst request stays up until the engine acknowledges the burst.

On the transmit side, a refill burst is requested while the FIFO holds no more entries than the watermark. On the receive side, a drain burst is requested once the FIFO holds more entries than the watermark. Each direction also has a single-transfer request. It tells the engine that one more entry fits (transmit) or that one entry is waiting (receive). The per-entry write and read strobes from the DMA engine pass straight through to the FIFOs.

Top module: `fifo_dma_pacer`

## Requirements
- R1: While reset is high and on the first clock after it, every request output is 0. After reset, all four registers read back 0.
- R2: The register address map is as follows. Address 0 is control: bit 0 is the transmit DMA enable and bit 1 is the receive DMA enable. Address 1 is the transmit watermark. Address 2 is the receive watermark. Address 3 bit 0 is the global enable. Unused bits read 0. Read data appears on the clock after a read strobe.
- R3: A write to either watermark register is ignored while the global enable is 1. The same write succeeds while the global enable is 0.
- R4: While the transmit DMA enable and the global enable are both set, an idle transmit channel raises its burst request on the clock after the transmit level is less than or equal to the transmit watermark.
- R5: While the receive DMA enable and the global enable are both set, an idle receive channel raises its burst request on the clock after the receive level is at least the receive watermark plus one.
- R6: A raised burst request stays high, whatever the FIFO level does, until a cycle with that direction's acknowledge high. The request is then low for the next two clocks before the watermark is tested again.
- R7: The transmit single request is high one clock after the transmit level is below the FIFO depth (256). The receive single request is high one clock after the receive level is nonzero. Each single request also requires its own enable bit and the global enable.
- R8: On the clock after the global enable or a direction's DMA enable reads 0, both request outputs of that direction are 0.
- R9: The DMA write strobe appears unchanged on the transmit FIFO push output, and the DMA read strobe appears unchanged on the receive FIFO pop output, in the same cycle.
- R10: The transmit and receive enable bits act independently. Setting only one of them produces requests only for that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one clock after reg_re |
| tx_level | input | 9 | Transmit FIFO entry count, 0 to 256 |
| rx_level | input | 9 | Receive FIFO entry count, 0 to 256 |
| dma_tx_ack | input | 1 | Transmit burst acknowledge from the DMA engine |
| dma_rx_ack | input | 1 | Receive burst acknowledge from the DMA engine |
| dma_tx_wr | input | 1 | Per-entry transmit write strobe from the DMA engine |
| dma_rx_rd | input | 1 | Per-entry receive read strobe from the DMA engine |
| tx_burst_req | output | 1 | Transmit burst request |
| tx_single_req | output | 1 | Transmit single-transfer request |
| rx_burst_req | output | 1 | Receive burst request |
| rx_single_req | output | 1 | Receive single-transfer request |
| fifo_tx_push | output | 1 | Push strobe to the transmit FIFO |
| fifo_rx_pop | output | 1 | Pop strobe from the receive FIFO |

## Verification
The assertions assume that the FIFO level inputs never exceed 256. They also assume that an acknowledge arrives only as a single-cycle pulse while the matching burst request is high. The stimulus keeps to these limits: every level it applies lies between 0 and 256. It raises each acknowledge for exactly one clock, and only after it has seen the matching request high. The bench also reprograms the watermarks only while the global enable is low, except in the scenario that deliberately checks that such writes are ignored.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_TX_WM = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_RX_WM = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_GLOB  = 2'd3;

  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,
    BST_REQ  = 2'd1,
    BST_GAP  = 2'd2
  } bst_e;
endpackage

// File: rtl/fdp_regs.sv
module fdp_regs
  import fdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_en,
  output logic              rx_en,
  output logic              glob_en,
  output logic [DATA_W-1:0] tx_wm,
  output logic [DATA_W-1:0] rx_wm
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en   <= 1'b0;
      rx_en   <= 1'b0;
      glob_en <= 1'b0;
      tx_wm   <= '0;
      rx_wm   <= '0;
    end else if (we) begin
      case (addr)
        ADR_CTRL: begin
          tx_en <= wdata[0];
          rx_en <= wdata[1];
        end
        ADR_TX_WM: if (!glob_en) tx_wm <= wdata;
        ADR_RX_WM: if (!glob_en) rx_wm <= wdata;
        default:   glob_en <= wdata[0];
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_CTRL:  rd_mux[1:0] = {rx_en, tx_en};
      ADR_TX_WM: rd_mux = tx_wm;
      ADR_RX_WM: rd_mux = rx_wm;
      default:   rd_mux[0] = glob_en;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_mux;
  end
endmodule

// File: rtl/fdp_level_cmp.sv
module fdp_level_cmp #(
  parameter bit IS_TX  = 1'b1,
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0]  level,
  input  logic [DATA_W-1:0] wm,
  output logic              burst_want,
  output logic              single_want
);
  logic [LVL_W-1:0] wm_ext;
  assign wm_ext = LVL_W'(wm);

  generate
    if (IS_TX) begin : g_tx
      assign burst_want  = (level <= wm_ext);
      assign single_want = (level < LVL_W'(DEPTH));
    end else begin : g_rx
      assign burst_want  = (level > wm_ext);
      assign single_want = (level != '0);
    end
  endgenerate
endmodule

// File: rtl/fdp_burst_fsm.sv
module fdp_burst_fsm
  import fdp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic want,
  input  logic ack,
  output logic req
);
  bst_e state_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q <= BST_IDLE;
    end else begin
      case (state_q)
        BST_IDLE: if (want) state_q <= BST_REQ;
        BST_REQ:  if (ack)  state_q <= BST_GAP;
        default:            state_q <= BST_IDLE;
      endcase
    end
  end

  assign req = (state_q == BST_REQ);
endmodule

// File: rtl/fifo_dma_pacer.sv
module fifo_dma_pacer
  import fdp_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              dma_tx_ack,
  input  logic              dma_rx_ack,
  input  logic              dma_tx_wr,
  input  logic              dma_rx_rd,
  output logic              tx_burst_req,
  output logic              tx_single_req,
  output logic              rx_burst_req,
  output logic              rx_single_req,
  output logic              fifo_tx_push,
  output logic              fifo_rx_pop
);
  localparam int NCH = 2;

  logic              tx_en_w, rx_en_w, glob_en_w;
  logic [DATA_W-1:0] tx_wm_w, rx_wm_w;

  fdp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .re      (reg_re),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .tx_en   (tx_en_w),
    .rx_en   (rx_en_w),
    .glob_en (glob_en_w),
    .tx_wm   (tx_wm_w),
    .rx_wm   (rx_wm_w)
  );

  logic [LVL_W-1:0]  lvl_a  [NCH];
  logic [DATA_W-1:0] wm_a   [NCH];
  logic              en_a   [NCH];
  logic              ack_a  [NCH];
  logic              breq_a [NCH];
  logic              sreq_a [NCH];

  assign lvl_a[0] = tx_level;
  assign lvl_a[1] = rx_level;
  assign wm_a[0]  = tx_wm_w;
  assign wm_a[1]  = rx_wm_w;
  assign en_a[0]  = tx_en_w & glob_en_w;
  assign en_a[1]  = rx_en_w & glob_en_w;
  assign ack_a[0] = dma_tx_ack;
  assign ack_a[1] = dma_rx_ack;

  generate
    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      logic burst_want, single_want, single_q;

      fdp_level_cmp #(
        .IS_TX  (gi == 0),
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
      ) u_cmp (
        .level       (lvl_a[gi]),
        .wm          (wm_a[gi]),
        .burst_want  (burst_want),
        .single_want (single_want)
      );

      fdp_burst_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .en   (en_a[gi]),
        .want (burst_want),
        .ack  (ack_a[gi]),
        .req  (breq_a[gi])
      );

      always_ff @(posedge clk) begin
        if (rst) single_q <= 1'b0;
        else     single_q <= en_a[gi] & single_want;
      end

      assign sreq_a[gi] = single_q;
    end
  endgenerate

  assign tx_burst_req  = breq_a[0];
  assign rx_burst_req  = breq_a[1];
  assign tx_single_req = sreq_a[0];
  assign rx_single_req = sreq_a[1];

  assign fifo_tx_push = dma_tx_wr;
  assign fifo_rx_pop  = dma_rx_rd;
endmodule

// File: rtl/fdp_chk.sv
module fdp_chk
  import fdp_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              dma_tx_ack,
  input logic              dma_rx_ack,
  input logic              dma_tx_wr,
  input logic              fifo_tx_push,
  input logic              tx_burst_req,
  input logic              tx_single_req,
  input logic              rx_burst_req,
  input logic              rx_single_req,
  input logic              tx_en,
  input logic              rx_en,
  input logic              glob_en,
  input logic [DATA_W-1:0] tx_wm,
  input logic [DATA_W-1:0] rx_wm
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !(tx_burst_req || rx_burst_req || tx_single_req || rx_single_req));

  // R3
  tx_wm_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (glob_en && reg_we && reg_addr == ADR_TX_WM) |=> $stable(tx_wm));

  // R3
  rx_wm_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (glob_en && reg_we && reg_addr == ADR_RX_WM) |=> $stable(rx_wm));

  // R4
  tx_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_burst_req) |-> $past(tx_level <= LVL_W'(tx_wm)));

  // R5
  rx_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_burst_req) |-> $past(rx_level > LVL_W'(rx_wm)));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_burst_req && !dma_tx_ack && tx_en && glob_en) |=> tx_burst_req);

  // R6
  tx_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_burst_req) |=> !tx_burst_req);

  // R6
  rx_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_burst_req) |=> !rx_burst_req);

  // R7
  tx_single_room_chk: assert property (@(posedge clk) disable iff (rst)
    tx_single_req |-> $past(tx_level < LVL_W'(DEPTH)));

  // R8
  tx_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_en && glob_en) |=> !(tx_burst_req || tx_single_req));

  // R8
  rx_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_en && glob_en) |=> !(rx_burst_req || rx_single_req));

  // R9
  always_comb begin
    pass_chk: assert (fifo_tx_push == dma_tx_wr);
  end
endmodule

bind fifo_dma_pacer fdp_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .tx_level      (tx_level),
  .rx_level      (rx_level),
  .dma_tx_ack    (dma_tx_ack),
  .dma_rx_ack    (dma_rx_ack),
  .dma_tx_wr     (dma_tx_wr),
  .fifo_tx_push  (fifo_tx_push),
  .tx_burst_req  (tx_burst_req),
  .tx_single_req (tx_single_req),
  .rx_burst_req  (rx_burst_req),
  .rx_single_req (rx_single_req),
  .tx_en         (tx_en_w),
  .rx_en         (rx_en_w),
  .glob_en       (glob_en_w),
  .tx_wm         (tx_wm_w),
  .rx_wm         (rx_wm_w)
);

// File: tb/tb_fifo_dma_pacer.sv
module tb_fifo_dma_pacer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [8:0] tx_level = '0, rx_level = '0;
  logic       dma_tx_ack = 1'b0, dma_rx_ack = 1'b0;
  logic       dma_tx_wr = 1'b0, dma_rx_rd = 1'b0;
  logic       tx_burst_req, tx_single_req, rx_burst_req, rx_single_req;
  logic       fifo_tx_push, fifo_rx_pop;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fifo_dma_pacer dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level),
    .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack),
    .dma_tx_wr(dma_tx_wr), .dma_rx_rd(dma_rx_rd),
    .tx_burst_req(tx_burst_req), .tx_single_req(tx_single_req),
    .rx_burst_req(rx_burst_req), .rx_single_req(rx_single_req),
    .fifo_tx_push(fifo_tx_push), .fifo_rx_pop(fifo_rx_pop)
  );

  task automatic chk(input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_re = 1'b1; reg_addr = a;
    tick();
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] txwm, input logic [7:0] rxwm, input logic [1:0] ctrl);
    wr(2'd3, 8'd0);
    wr(2'd1, txwm);
    wr(2'd2, rxwm);
    wr(2'd0, {6'd0, ctrl});
    wr(2'd3, 8'd1);
  endtask

  task automatic ack_tx();
    dma_tx_ack = 1'b1;
    tick();
    dma_tx_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    tx_level = 9'd0; rx_level = 9'd100;
    rst = 1'b1;
    tick();
    chk("R1 burst/single during reset",
        {tx_burst_req, rx_burst_req, tx_single_req, rx_single_req}, 0);
    rst = 1'b0;
    tick();
    chk("R1 outputs first clock after reset",
        {tx_burst_req, rx_burst_req, tx_single_req, rx_single_req}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk($sformatf("R1 register %0d after reset", a), d, 0);
    end
  endtask

  task automatic t_regs();
    logic [7:0] d;
    do_reset();
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 control keeps only bits 1:0", d, 3);
    wr(2'd1, 8'd200); rd(2'd1, d); chk("R2 tx watermark readback", d, 200);
    wr(2'd2, 8'd17); rd(2'd2, d); chk("R2 rx watermark readback", d, 17);
    wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 global enable reads bit 0", d, 1);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    do_reset();
    cfg(8'd5, 8'd6, 2'b00);
    wr(2'd1, 8'd77); wr(2'd2, 8'd88);
    rd(2'd1, d); chk("R3 tx watermark write ignored while enabled", d, 5);
    rd(2'd2, d); chk("R3 rx watermark write ignored while enabled", d, 6);
    wr(2'd3, 8'd0);
    wr(2'd1, 8'd77);
    rd(2'd1, d); chk("R3 tx watermark write accepted while disabled", d, 77);
  endtask

  task automatic t_tx_burst();
    do_reset();
    tx_level = 9'd100; rx_level = 9'd0;
    cfg(8'd100, 8'd0, 2'b01);
    tick();
    chk("R4 tx request at level equal to watermark", tx_burst_req, 1);
    ack_tx();
    tx_level = 9'd101;
    tick(); tick(); tick();
    chk("R4 tx request absent above watermark", tx_burst_req, 0);
    tx_level = 9'd99;
    tick(); tick();
    chk("R4 tx request below watermark", tx_burst_req, 1);
  endtask

  task automatic t_rx_burst();
    do_reset();
    tx_level = 9'd256; rx_level = 9'd10;
    cfg(8'd0, 8'd10, 2'b10);
    tick(); tick();
    chk("R5 rx request absent at level equal to watermark", rx_burst_req, 0);
    rx_level = 9'd11;
    tick();
    chk("R5 rx request at watermark plus one", rx_burst_req, 1);
    do_reset();
    rx_level = 9'd256;
    cfg(8'd0, 8'd255, 2'b10);
    tick();
    chk("R5 rx request full FIFO, top watermark", rx_burst_req, 1);
  endtask

  task automatic t_handshake();
    do_reset();
    tx_level = 9'd0; rx_level = 9'd0;
    cfg(8'd5, 8'd0, 2'b01);
    tick();
    chk("R6 request raised", tx_burst_req, 1);
    tx_level = 9'd200;
    tick(); tick();
    chk("R6 request held without acknowledge", tx_burst_req, 1);
    tx_level = 9'd0;
    ack_tx();
    chk("R6 request dropped after acknowledge", tx_burst_req, 0);
    tick();
    chk("R6 request still low second clock", tx_burst_req, 0);
    tick();
    chk("R6 request re-raised third clock", tx_burst_req, 1);
  endtask

  task automatic t_single();
    do_reset();
    tx_level = 9'd256; rx_level = 9'd0;
    cfg(8'd0, 8'd200, 2'b11);
    tick(); tick();
    chk("R7 tx single low with full FIFO", tx_single_req, 0);
    chk("R7 rx single low with empty FIFO", rx_single_req, 0);
    tx_level = 9'd255; rx_level = 9'd1;
    tick();
    chk("R7 tx single with one free entry", tx_single_req, 1);
    chk("R7 rx single with one entry", rx_single_req, 1);
  endtask

  task automatic t_disable();
    do_reset();
    tx_level = 9'd0; rx_level = 9'd50;
    cfg(8'd10, 8'd0, 2'b11);
    tick();
    chk("R8 precondition tx request", tx_burst_req, 1);
    wr(2'd0, 8'b10);
    tick();
    chk("R8 tx burst cleared by tx enable", tx_burst_req, 0);
    chk("R8 tx single cleared by tx enable", tx_single_req, 0);
    chk("R8 rx burst kept", rx_burst_req, 1);
    wr(2'd3, 8'd0);
    tick();
    chk("R8 rx burst cleared by global enable", rx_burst_req, 0);
    chk("R8 rx single cleared by global enable", rx_single_req, 0);
  endtask

  task automatic t_indep();
    do_reset();
    tx_level = 9'd0; rx_level = 9'd5;
    cfg(8'd0, 8'd0, 2'b10);
    tick(); tick();
    chk("R10 tx burst off with only rx enabled", tx_burst_req, 0);
    chk("R10 tx single off with only rx enabled", tx_single_req, 0);
    chk("R10 rx burst on", rx_burst_req, 1);
    chk("R10 rx single on", rx_single_req, 1);
  endtask

  task automatic t_pass();
    dma_tx_wr = 1'b1; dma_rx_rd = 1'b0;
    #1;
    chk("R9 push follows write strobe", fifo_tx_push, 1);
    chk("R9 pop follows read strobe low", fifo_rx_pop, 0);
    dma_tx_wr = 1'b0; dma_rx_rd = 1'b1;
    #1;
    chk("R9 push low", fifo_tx_push, 0);
    chk("R9 pop follows read strobe", fifo_rx_pop, 1);
    dma_rx_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_regs();
    t_lock();
    t_tx_burst();
    t_rx_burst();
    t_handshake();
    t_single();
    t_disable();
    t_indep();
    t_pass();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule